// File: doc/BRIEF.md
# Linked-List DMA Tag Sequencer

This block steps through a chain of 128-bit descriptors ("tags") that sit in a ring buffer shared with a producer. For each descriptor it reads one quadword from tag memory, decodes the descriptor kind, and loads the channel's quadword count and data address. It then works out where the next descriptor lives and decides whether the chain stops after this one. All ring-relative addresses are folded as `fold(x) = ring_base + (x & ring_mask)`. Moving the data itself is left to a downstream engine, which reports back with `burst_done`.

The sequencer can pass the upper half of each descriptor (two 32-bit words) to a consumer over a valid/ready handshake before it acts on the descriptor. It keeps a count of quadwords the producer has made available. When the next descriptor address has caught up with the producer's write address, it stops and raises a ring-empty interrupt, at most once per empty episode. When the chain ends it drops its running flag and pulses a done interrupt. A 0..16 FIFO fill level is reported throughout.

Top module: `tagchain_seq`

## Requirements
- R1: After a synchronous reset, `running`, `tag_loaded`, `tag_rd_en`, `tw_valid`, both interrupts, `fill_level`, `avail` and `ch_qwc` are all zero.
- R2: A `go` pulse while idle loads `start_tadr` as the tag address and sets `running`. Each fetch is a one-cycle `tag_rd_en` at the current tag address, with read data one cycle later. The descriptor fields are: quadword count in bits 15:0, kind in bits 30:28, IRQ flag in bit 31, address in bits 62:32.
- R3: Kind 0: `ch_madr` = address field, next tag = fold(tag+16), and the chain ends.
- R4: Kind 1: `ch_madr` = fold(tag+16), next tag = fold(ch_madr + 16*count), and the chain continues.
- R5: Kind 2: `ch_madr` = fold(tag+16), next tag = the address field without folding, and the chain continues.
- R6: Kinds 3 and 4: `ch_madr` = address field, next tag = fold(tag+16), and the chain continues.
- R7: Kind 7, and the unused kinds 5 and 6: `ch_madr` = fold(tag+16), next tag = fold(ch_madr + 16*count), and the chain ends.
- R8: When `tie` is 1 and the descriptor's IRQ bit is 1, the chain ends after this descriptor whatever its kind.
- R9: With `tte` set, bits 95:64 and then bits 127:96 are offered on `tw_data` before the descriptor takes effect. While `tw_ready` is low the word is held stable and no descriptor is loaded. Sending resumes where it stopped.
- R10: At each load, `fill_level` = min(count, 16). It becomes 0 on a ring-empty event or at the end of the chain.
- R11: When a new descriptor is needed and the tag address equals `prod_addr`, `avail` is cleared, `fill_level` becomes 0 and the sequencer waits. `irq_empty` pulses only if no empty event is already pending.
- R12: `add_valid` adds `add_qwc` to `avail`, clears the pending-empty flag and restarts a waiting channel. It sets `fill_level` to 16 only if an empty event was pending; otherwise `fill_level` is unchanged.
- R13: Each load lowers `avail` by one (floored at 0). After the data for a descriptor is done (`burst_done`, or at once if the count is 0), an ending chain clears `running` and pulses `irq_done`. The same cycle also checks ring-empty per R11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| go | input | 1 | Start pulse, taken only while idle |
| start_tadr | input | AW (32) | First descriptor byte address |
| ring_base | input | AW (32) | Ring base address |
| ring_mask | input | AW (32) | Ring offset mask |
| tte | input | 1 | Forward descriptor upper words |
| tie | input | 1 | Honour descriptor IRQ bit |
| prod_addr | input | AW (32) | Producer's current write address |
| add_valid | input | 1 | Producer added quadwords |
| add_qwc | input | 16 | Quadwords added |
| burst_done | input | 1 | Data for the loaded descriptor finished |
| tag_rd_en | output | 1 | Tag memory read enable |
| tag_rd_addr | output | AW (32) | Tag memory byte address |
| tag_rd_data | input | 128 | Tag memory data, one cycle after the read |
| tw_valid | output | 1 | Forwarded word valid |
| tw_data | output | 32 | Forwarded word |
| tw_ready | input | 1 | Consumer accepts word |
| running | output | 1 | Channel active |
| tag_loaded | output | 1 | One-cycle pulse when a descriptor takes effect |
| ch_qwc | output | 16 | Loaded quadword count |
| ch_madr | output | AW (32) | Loaded data address |
| tag_addr | output | AW (32) | Current/next descriptor address |
| chain_end | output | 1 | Chain ends after current descriptor |
| avail | output | AVW (20) | Quadwords available in ring |
| fill_level | output | FW (5) | FIFO fill level 0..16 |
| irq_empty | output | 1 | Ring-empty interrupt pulse |
| irq_done | output | 1 | Chain-done interrupt pulse |

## Verification
The hardest case to reach is the once-only ring-empty rule. The pending flag is set only by an earlier empty event, and it has to survive until a later one without any data being added in between. The bench builds this in three steps. It first runs a chain whose last descriptor leaves the tag address equal to the producer address, so the end-of-chain check raises the interrupt. It then starts a new chain directly at that address and checks that no second pulse appears. Finally it adds data and checks that the next empty event does pulse again. A sweep over every kind code, the IRQ/enable pairs, three counts and both forwarding modes covers the address-update rules, with folds landing on both sides of the ring end.

// File: rtl/tagchain_pkg.sv
package tagchain_pkg;

  localparam int TAG_W   = 128;
  localparam int CNT_LSB = 0;
  localparam int CNT_MSB = 15;
  localparam int KND_LSB = 28;
  localparam int KND_MSB = 30;
  localparam int IRQ_POS = 31;
  localparam int ADF_LSB = 32;
  localparam int ADF_MSB = 62;
  localparam int CNT_W   = CNT_MSB - CNT_LSB + 1;
  localparam int ADF_W   = ADF_MSB - ADF_LSB + 1;

  typedef enum logic [2:0] {
    K_REFE = 3'd0,
    K_CNT  = 3'd1,
    K_NEXT = 3'd2,
    K_REF  = 3'd3,
    K_REFS = 3'd4,
    K_END  = 3'd7
  } tag_kind_e;

  typedef enum logic [3:0] {
    S_IDLE,
    S_CHECK,
    S_WAIT,
    S_FETCH,
    S_CAPT,
    S_SEND,
    S_APPLY,
    S_BUSY,
    S_FINISH
  } seq_state_e;

endpackage

// File: rtl/tagchain_decode.sv
module tagchain_decode
  import tagchain_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic [CNT_W-1:0] cnt_f,
  input  logic [2:0]       kind_f,
  input  logic             irq_f,
  input  logic [ADF_W-1:0] adr_f,
  input  logic [AW-1:0]    tadr,
  input  logic [AW-1:0]    rbase,
  input  logic [AW-1:0]    rmask,
  input  logic             tie,
  output logic [AW-1:0]    madr,
  output logic [AW-1:0]    ntadr,
  output logic             ends
);

  localparam logic [AW-1:0] QSTEP = AW'(16);

  function automatic logic [AW-1:0] fold(input logic [AW-1:0] a,
                                         input logic [AW-1:0] b,
                                         input logic [AW-1:0] m);
    return b + (a & m);
  endfunction

  logic [AW-1:0] after_tag;
  logic [AW-1:0] after_data;
  logic [AW-1:0] field_adr;

  always_comb begin
    after_tag  = fold(tadr + QSTEP, rbase, rmask);
    field_adr  = AW'(adr_f);
    after_data = fold(after_tag + (AW'(cnt_f) << 4), rbase, rmask);
    case (kind_f)
      K_REFE: begin
        madr  = field_adr;
        ntadr = after_tag;
        ends  = 1'b1;
      end
      K_CNT: begin
        madr  = after_tag;
        ntadr = after_data;
        ends  = 1'b0;
      end
      K_NEXT: begin
        madr  = after_tag;
        ntadr = field_adr;
        ends  = 1'b0;
      end
      K_REF, K_REFS: begin
        madr  = field_adr;
        ntadr = after_tag;
        ends  = 1'b0;
      end
      default: begin
        madr  = after_tag;
        ntadr = after_data;
        ends  = 1'b1;
      end
    endcase
    if (tie && irq_f) ends = 1'b1;
  end

endmodule

// File: rtl/tagchain_fwd.sv
module tagchain_fwd #(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [2*WORD_W-1:0] words,
  input  logic              tw_ready,
  output logic              tw_valid,
  output logic [WORD_W-1:0] tw_data,
  output logic              done
);

  logic [WORD_W-1:0] second_q;
  logic              sel_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      tw_valid <= 1'b0;
      tw_data  <= '0;
      second_q <= '0;
      sel_q    <= 1'b0;
    end else if (start) begin
      tw_valid <= 1'b1;
      tw_data  <= words[WORD_W-1:0];
      second_q <= words[2*WORD_W-1:WORD_W];
      sel_q    <= 1'b0;
    end else if (tw_valid && tw_ready) begin
      if (!sel_q) begin
        tw_data <= second_q;
        sel_q   <= 1'b1;
      end else begin
        tw_valid <= 1'b0;
        sel_q    <= 1'b0;
      end
    end
  end

  assign done = tw_valid && tw_ready && sel_q;

  // R9: a word that is not taken stays on the port unchanged
  p_hold_word_r9: assert property (@(posedge clk) disable iff (rst)
    (tw_valid && !tw_ready) |=> (tw_valid && $stable(tw_data)));

endmodule

// File: rtl/tagchain_level.sv
module tagchain_level
  import tagchain_pkg::*;
#(
  parameter int AVW      = 20,
  parameter int FILL_MAX = 16,
  parameter int FW       = $clog2(FILL_MAX + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             add_valid,
  input  logic [CNT_W-1:0] add_qwc,
  input  logic             ev_empty,
  input  logic             ev_load,
  input  logic             ev_end,
  input  logic [CNT_W-1:0] load_qwc,
  output logic [AVW-1:0]   avail,
  output logic [FW-1:0]    fill,
  output logic             irq_empty
);

  logic           pend_q;
  logic [AVW-1:0] base;
  logic [FW-1:0]  capped;

  always_comb begin
    if (ev_empty)                  base = '0;
    else if (ev_load && avail != 0) base = avail - AVW'(1);
    else                           base = avail;
    capped = (load_qwc > CNT_W'(FILL_MAX)) ? FW'(FILL_MAX) : FW'(load_qwc);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      avail     <= '0;
      fill      <= '0;
      pend_q    <= 1'b0;
      irq_empty <= 1'b0;
    end else begin
      avail     <= base + (add_valid ? AVW'(add_qwc) : '0);
      irq_empty <= ev_empty && !pend_q;
      if (add_valid)     pend_q <= 1'b0;
      else if (ev_empty) pend_q <= 1'b1;
      if (ev_empty || ev_end)        fill <= '0;
      else if (ev_load)              fill <= capped;
      else if (add_valid && pend_q)  fill <= FW'(FILL_MAX);
    end
  end

  // R11: after an empty pulse the pending flag is set
  p_pend_after_irq_r11: assert property (@(posedge clk) disable iff (rst)
    irq_empty |-> pend_q);

  // R10: level never exceeds its cap
  p_fill_cap_r10: assert property (@(posedge clk) disable iff (rst)
    fill <= FW'(FILL_MAX));

endmodule

// File: rtl/tagchain_seq.sv
module tagchain_seq
  import tagchain_pkg::*;
#(
  parameter int AW       = 32,
  parameter int AVW      = 20,
  parameter int FILL_MAX = 16,
  localparam int FW      = $clog2(FILL_MAX + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               go,
  input  logic [AW-1:0]      start_tadr,
  input  logic [AW-1:0]      ring_base,
  input  logic [AW-1:0]      ring_mask,
  input  logic               tte,
  input  logic               tie,
  input  logic [AW-1:0]      prod_addr,
  input  logic               add_valid,
  input  logic [CNT_W-1:0]   add_qwc,
  input  logic               burst_done,
  output logic               tag_rd_en,
  output logic [AW-1:0]      tag_rd_addr,
  input  logic [TAG_W-1:0]   tag_rd_data,
  output logic               tw_valid,
  output logic [31:0]        tw_data,
  input  logic               tw_ready,
  output logic               running,
  output logic               tag_loaded,
  output logic [CNT_W-1:0]   ch_qwc,
  output logic [AW-1:0]      ch_madr,
  output logic [AW-1:0]      tag_addr,
  output logic               chain_end,
  output logic [AVW-1:0]     avail,
  output logic [FW-1:0]      fill_level,
  output logic               irq_empty,
  output logic               irq_done
);

  seq_state_e       st_q;
  logic [AW-1:0]    tadr_q, madr_q, rd_addr_q;
  logic [CNT_W-1:0] qwc_q;
  logic             end_q, run_q, load_q, done_q, rd_en_q;

  logic [CNT_W-1:0] f_cnt;
  logic [2:0]       f_kind;
  logic             f_irq;
  logic [ADF_W-1:0] f_adr;

  logic [AW-1:0]    d_madr, d_ntadr;
  logic             d_end;
  logic             ring_hit, ev_empty, ev_load, ev_end, fwd_start, fwd_done;
  logic             unused_tag_bits;

  assign unused_tag_bits = ^{tag_rd_data[63], tag_rd_data[KND_LSB-1:CNT_MSB+1]};

  tagchain_decode #(.AW(AW)) u_decode (
    .cnt_f (f_cnt),
    .kind_f(f_kind),
    .irq_f (f_irq),
    .adr_f (f_adr),
    .tadr  (tadr_q),
    .rbase (ring_base),
    .rmask (ring_mask),
    .tie   (tie),
    .madr  (d_madr),
    .ntadr (d_ntadr),
    .ends  (d_end)
  );

  tagchain_fwd #(.WORD_W(32)) u_fwd (
    .clk     (clk),
    .rst     (rst),
    .start   (fwd_start),
    .words   (tag_rd_data[TAG_W-1:64]),
    .tw_ready(tw_ready),
    .tw_valid(tw_valid),
    .tw_data (tw_data),
    .done    (fwd_done)
  );

  tagchain_level #(.AVW(AVW), .FILL_MAX(FILL_MAX), .FW(FW)) u_level (
    .clk      (clk),
    .rst      (rst),
    .add_valid(add_valid),
    .add_qwc  (add_qwc),
    .ev_empty (ev_empty),
    .ev_load  (ev_load),
    .ev_end   (ev_end),
    .load_qwc (f_cnt),
    .avail    (avail),
    .fill     (fill_level),
    .irq_empty(irq_empty)
  );

  always_comb begin
    ring_hit  = (tadr_q == prod_addr);
    ev_load   = (st_q == S_APPLY);
    ev_end    = (st_q == S_FINISH);
    fwd_start = (st_q == S_CAPT) && tte;
    ev_empty  = ((st_q == S_CHECK) || (st_q == S_FINISH)) && ring_hit && !add_valid;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= S_IDLE;
      tadr_q    <= '0;
      madr_q    <= '0;
      rd_addr_q <= '0;
      qwc_q     <= '0;
      end_q     <= 1'b0;
      run_q     <= 1'b0;
      load_q    <= 1'b0;
      done_q    <= 1'b0;
      rd_en_q   <= 1'b0;
      f_cnt     <= '0;
      f_kind    <= '0;
      f_irq     <= 1'b0;
      f_adr     <= '0;
    end else begin
      load_q  <= 1'b0;
      done_q  <= 1'b0;
      rd_en_q <= 1'b0;
      case (st_q)
        S_IDLE: if (go) begin
          tadr_q <= start_tadr;
          run_q  <= 1'b1;
          end_q  <= 1'b0;
          st_q   <= S_CHECK;
        end
        S_CHECK: if (!add_valid) begin
          if (ring_hit) st_q <= S_WAIT;
          else begin
            rd_en_q   <= 1'b1;
            rd_addr_q <= tadr_q;
            st_q      <= S_FETCH;
          end
        end
        S_WAIT:  if (add_valid) st_q <= S_CHECK;
        S_FETCH: st_q <= S_CAPT;
        S_CAPT: begin
          f_cnt  <= tag_rd_data[CNT_MSB:CNT_LSB];
          f_kind <= tag_rd_data[KND_MSB:KND_LSB];
          f_irq  <= tag_rd_data[IRQ_POS];
          f_adr  <= tag_rd_data[ADF_MSB:ADF_LSB];
          st_q   <= tte ? S_SEND : S_APPLY;
        end
        S_SEND: if (fwd_done) st_q <= S_APPLY;
        S_APPLY: begin
          qwc_q  <= f_cnt;
          madr_q <= d_madr;
          tadr_q <= d_ntadr;
          end_q  <= d_end;
          load_q <= 1'b1;
          st_q   <= S_BUSY;
        end
        S_BUSY: if (qwc_q == '0 || burst_done) st_q <= end_q ? S_FINISH : S_CHECK;
        S_FINISH: begin
          run_q  <= 1'b0;
          done_q <= 1'b1;
          st_q   <= S_IDLE;
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign tag_rd_en   = rd_en_q;
  assign tag_rd_addr = rd_addr_q;
  assign running     = run_q;
  assign tag_loaded  = load_q;
  assign ch_qwc      = qwc_q;
  assign ch_madr     = madr_q;
  assign tag_addr    = tadr_q;
  assign chain_end   = end_q;
  assign irq_done    = done_q;

  // R2: a read request lasts exactly one cycle
  p_single_read_r2: assert property (@(posedge clk) disable iff (rst)
    tag_rd_en |=> !tag_rd_en);

  // R2: descriptors only take effect while the channel runs
  p_load_running_r2: assert property (@(posedge clk) disable iff (rst)
    tag_loaded |-> running);

  // R10: fill level at load is the capped count
  p_load_fill_r10: assert property (@(posedge clk) disable iff (rst)
    tag_loaded |-> (fill_level == ((ch_qwc > CNT_W'(FILL_MAX)) ? FW'(FILL_MAX) : FW'(ch_qwc))));

  // R13: done pulse comes with the channel stopped, level cleared, end flag set
  p_done_stops_r13: assert property (@(posedge clk) disable iff (rst)
    irq_done |-> (!running && fill_level == '0 && chain_end));

  // R11: empty pulse leaves nothing available
  p_empty_clears_r11: assert property (@(posedge clk) disable iff (rst)
    irq_empty |-> (avail == '0 && fill_level == '0));

endmodule

// File: tb/tagchain_seq_test.sv
module tagchain_seq_test;
  localparam int AW = 32;
  localparam logic [31:0] RB = 32'h100;
  localparam logic [31:0] RM = 32'hF0;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst, go, tte, tie, add_valid, burst_done, tw_ready;
  logic [31:0] start_tadr, ring_base, ring_mask, prod_addr;
  logic [15:0] add_qwc;
  logic tag_rd_en, tw_valid, running, tag_loaded, chain_end, irq_empty, irq_done;
  logic [31:0] tag_rd_addr, tw_data, ch_madr, tag_addr;
  logic [127:0] tag_rd_data;
  logic [15:0] ch_qwc;
  logic [19:0] avail;
  logic [4:0] fill_level;

  tagchain_seq uut (
    .clk(clk), .rst(rst), .go(go), .start_tadr(start_tadr),
    .ring_base(ring_base), .ring_mask(ring_mask), .tte(tte), .tie(tie),
    .prod_addr(prod_addr), .add_valid(add_valid), .add_qwc(add_qwc),
    .burst_done(burst_done), .tag_rd_en(tag_rd_en), .tag_rd_addr(tag_rd_addr),
    .tag_rd_data(tag_rd_data), .tw_valid(tw_valid), .tw_data(tw_data),
    .tw_ready(tw_ready), .running(running), .tag_loaded(tag_loaded),
    .ch_qwc(ch_qwc), .ch_madr(ch_madr), .tag_addr(tag_addr),
    .chain_end(chain_end), .avail(avail), .fill_level(fill_level),
    .irq_empty(irq_empty), .irq_done(irq_done)
  );

  logic [127:0] mem [0:255];
  always @(posedge clk) if (tag_rd_en) tag_rd_data <= mem[tag_rd_addr[11:4]];

  int n_empty = 0, n_done = 0, n_load = 0, n_words = 0;
  logic [31:0] wlog [0:1023];
  logic [31:0] last_rd = '0;
  always @(posedge clk) begin
    if (irq_empty) n_empty++;
    if (irq_done) n_done++;
    if (tag_loaded) n_load++;
    if (tw_valid && tw_ready) begin wlog[n_words % 1024] = tw_data; n_words++; end
    if (tag_rd_en) last_rd = tag_rd_addr;
  end

  int n_chk = 0, n_bad = 0;

  task automatic chk(input string what, input logic [63:0] got, input logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", what, got, exp);
    end
  endtask

  function automatic logic [31:0] fold(input logic [31:0] a);
    return RB + (a & RM);
  endfunction

  function automatic logic [127:0] mk_tag(input logic [31:0] w1, input logic [31:0] w0,
      input logic [30:0] adr, input logic irq, input logic [2:0] kind, input logic [15:0] q);
    return {w1, w0, 1'b0, adr, irq, kind, 12'h000, q};
  endfunction

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1; step(3); rst = 1'b0; step(1);
  endtask

  task automatic pulse_add(input logic [15:0] q);
    add_valid = 1'b1; add_qwc = q; step(1); add_valid = 1'b0; add_qwc = '0;
  endtask

  task automatic pulse_go(input logic [31:0] t);
    start_tadr = t; go = 1'b1; step(1); go = 1'b0;
  endtask

  task automatic pulse_burst();
    burst_done = 1'b1; step(1); burst_done = 1'b0;
  endtask

  task automatic wait_loaded(input string what);
    int k;
    for (k = 0; k < 60; k++) begin
      @(negedge clk);
      if (tag_loaded) break;
    end
    chk({what, " load seen"}, 64'(k < 60), 64'd1);
  endtask

  initial begin
    int ne, nd, nl, nw;
    rst = 1'b1; go = 1'b0; tte = 1'b0; tie = 1'b0; add_valid = 1'b0; add_qwc = '0;
    burst_done = 1'b0; tw_ready = 1'b1; start_tadr = '0; ring_base = RB;
    ring_mask = RM; prod_addr = '0;
    for (int i = 0; i < 256; i++) mem[i] = '0;
    do_reset();

    // R1 reset state
    chk("R1 running", 64'(running), 0);
    chk("R1 tag_loaded", 64'(tag_loaded), 0);
    chk("R1 tag_rd_en", 64'(tag_rd_en), 0);
    chk("R1 tw_valid", 64'(tw_valid), 0);
    chk("R1 irq_empty", 64'(irq_empty), 0);
    chk("R1 irq_done", 64'(irq_done), 0);
    chk("R1 fill", 64'(fill_level), 0);
    chk("R1 avail", 64'(avail), 0);
    chk("R1 ch_qwc", 64'(ch_qwc), 0);

    // Sweep over kinds, IRQ/enable, counts, forwarding
    begin
      int k = 0;
      for (int kd = 0; kd < 8; kd++)
      for (int ti = 0; ti < 2; ti++)
      for (int ir = 0; ir < 2; ir++)
      for (int qi = 0; qi < 3; qi++)
      for (int fw = 0; fw < 2; fw++) begin
        logic [31:0] t, a, em, en, w0, w1;
        logic [15:0] q;
        logic ee;
        string rt;
        q = (qi == 0) ? 16'd0 : (qi == 1) ? 16'd3 : 16'd20;
        t = RB + 32'((k * 3) % 16) * 32'd16;
        a = fold(t + 32'((k % 7) + 2) * 32'd16);
        w0 = 32'hA500_0000 | 32'(k);
        w1 = 32'h5A00_0000 | 32'(k);
        case (kd)
          0: begin em = a; en = fold(t + 16); ee = 1'b1; rt = "R3"; end
          1: begin em = fold(t + 16); en = fold(em + {q, 4'h0}); ee = 1'b0; rt = "R4"; end
          2: begin em = fold(t + 16); en = a; ee = 1'b0; rt = "R5"; end
          3, 4: begin em = a; en = fold(t + 16); ee = 1'b0; rt = "R6"; end
          default: begin em = fold(t + 16); en = fold(em + {q, 4'h0}); ee = 1'b1; rt = "R7"; end
        endcase
        if (ti == 1 && ir == 1) begin ee = 1'b1; rt = {rt, "/R8"}; end
        do_reset();
        mem[t[11:4]] = mk_tag(w1, w0, a[30:0], ir[0], kd[2:0], q);
        tte = fw[0]; tie = ti[0]; tw_ready = 1'b1; prod_addr = en;
        pulse_add(16'd5);
        ne = n_empty; nd = n_done; nw = n_words;
        pulse_go(t);
        wait_loaded({rt, " sweep"});
        chk({rt, " madr"}, 64'(ch_madr), 64'(em));
        chk({rt, " next tag"}, 64'(tag_addr), 64'(en));
        chk({rt, " end flag"}, 64'(chain_end), 64'(ee));
        chk("R2 count", 64'(ch_qwc), 64'(q));
        chk("R2 read addr", 64'(last_rd), 64'(t));
        chk("R10 fill at load", 64'(fill_level), 64'((q > 16) ? 16 : q));
        chk("R13 avail after load", 64'(avail), 64'd4);
        if (fw == 1) begin
          chk("R9 word count", 64'(n_words - nw), 64'd2);
          chk("R9 first word", 64'(wlog[nw % 1024]), 64'(w0));
          chk("R9 second word", 64'(wlog[(nw + 1) % 1024]), 64'(w1));
        end else chk("R9 no words", 64'(n_words - nw), 64'd0);
        if (q != 0) pulse_burst();
        step(8);
        chk("R13 running after", 64'(running), 64'(!ee));
        chk("R13 done pulses", 64'(n_done - nd), 64'(ee));
        chk("R11 empty pulses", 64'(n_empty - ne), 64'd1);
        chk("R11 avail cleared", 64'(avail), 64'd0);
        chk("R10 fill cleared", 64'(fill_level), 64'd0);
        k++;
      end
    end

    // Chain across the ring with empty stall and refill
    do_reset();
    tte = 1'b0; tie = 1'b0;
    mem[8'h10] = mk_tag(32'h0, 32'h0, 31'h0, 1'b0, 3'd1, 16'd2);
    mem[8'h13] = mk_tag(32'h0, 32'h0, 31'h1E0, 1'b0, 3'd2, 16'd1);
    mem[8'h1E] = mk_tag(32'h0, 32'h0, 31'h0, 1'b0, 3'd7, 16'd4);
    prod_addr = 32'h1E0;
    pulse_add(16'd3);
    ne = n_empty; nd = n_done; nl = n_load;
    pulse_go(32'h100);
    wait_loaded("R4 chain");
    chk("R4 chain madr", 64'(ch_madr), 64'h110);
    chk("R4 chain next", 64'(tag_addr), 64'h130);
    chk("R13 avail 2", 64'(avail), 64'd2);
    pulse_burst();
    wait_loaded("R5 chain");
    chk("R5 chain madr", 64'(ch_madr), 64'h140);
    chk("R5 chain next", 64'(tag_addr), 64'h1E0);
    chk("R13 avail 1", 64'(avail), 64'd1);
    pulse_burst();
    step(6);
    chk("R11 empty once", 64'(n_empty - ne), 64'd1);
    chk("R11 avail zero", 64'(avail), 64'd0);
    chk("R11 fill zero", 64'(fill_level), 64'd0);
    chk("R11 still running", 64'(running), 64'd1);
    step(10);
    chk("R11 waits without load", 64'(n_load - nl), 64'd2);
    prod_addr = 32'h130;
    pulse_add(16'd6);
    chk("R12 fill 16 after refill", 64'(fill_level), 64'd16);
    chk("R12 avail add", 64'(avail), 64'd6);
    wait_loaded("R7 chain");
    chk("R7 chain madr", 64'(ch_madr), 64'h1F0);
    chk("R7 chain next wraps", 64'(tag_addr), 64'h130);
    chk("R7 chain end", 64'(chain_end), 64'd1);
    chk("R10 fill 4", 64'(fill_level), 64'd4);
    chk("R13 avail 5", 64'(avail), 64'd5);
    pulse_add(16'd2);
    chk("R12 add keeps fill", 64'(fill_level), 64'd4);
    chk("R12 avail 7", 64'(avail), 64'd7);
    pulse_burst();
    step(6);
    chk("R13 done once", 64'(n_done - nd), 64'd1);
    chk("R13 stopped", 64'(running), 64'd0);
    chk("R13 end-time empty", 64'(n_empty - ne), 64'd2);
    chk("R13 avail cleared", 64'(avail), 64'd0);

    // Once-only: empty while already pending raises nothing
    nl = n_load;
    pulse_go(32'h130);
    step(6);
    chk("R11 no second pulse", 64'(n_empty - ne), 64'd2);
    chk("R11 waiting runs", 64'(running), 64'd1);
    chk("R11 no load when empty", 64'(n_load - nl), 64'd0);
    prod_addr = 32'h1E0;
    pulse_add(16'd1);
    chk("R12 refill fill 16", 64'(fill_level), 64'd16);
    wait_loaded("R12 restart");
    chk("R12 restart madr", 64'(ch_madr), 64'h140);
    chk("R10 fill 1", 64'(fill_level), 64'd1);
    pulse_burst();
    step(6);
    chk("R11 pulse after refill", 64'(n_empty - ne), 64'd3);

    // Forwarding stall and resume
    do_reset();
    mem[8'h10] = mk_tag(32'h2222_0002, 32'h1111_0001, 31'h180, 1'b0, 3'd3, 16'd2);
    tte = 1'b1; tie = 1'b0; tw_ready = 1'b0; prod_addr = 32'h110;
    nl = n_load; nw = n_words;
    pulse_go(32'h100);
    step(12);
    chk("R9 stall valid", 64'(tw_valid), 64'd1);
    chk("R9 stall word0", 64'(tw_data), 64'h1111_0001);
    chk("R9 stall no load", 64'(n_load - nl), 64'd0);
    tw_ready = 1'b1; step(1); tw_ready = 1'b0;
    chk("R9 word1 offered", 64'(tw_data), 64'h2222_0002);
    step(5);
    chk("R9 word1 held", 64'(tw_data), 64'h2222_0002);
    chk("R9 still no load", 64'(n_load - nl), 64'd0);
    tw_ready = 1'b1;
    wait_loaded("R9 resume");
    chk("R9 words sent", 64'(n_words - nw), 64'd2);
    chk("R9 order", 64'(wlog[nw % 1024]), 64'h1111_0001);
    chk("R6 madr after forward", 64'(ch_madr), 64'h180);
    chk("R6 next after forward", 64'(tag_addr), 64'h110);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule